// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block sits behind a CAN receiver and chooses which receive mailbox, if any, keeps an incoming frame. Each mailbox holds an acceptance identifier, a format flag, a remote flag and mask-enable bits. These are compared in parallel against the frame's identifier, extension flag and remote flag. A mailbox can compare every identifier bit exactly, or it can ignore the bits that are set in a mask. Ordinary mailboxes use one shared mask. The last mailbox is receive-only and uses its own private mask, so it can take in a different family of identifiers.

When one or more mailboxes accept a frame, the one with the highest index wins. The filter writes the identifier, length code, eight data bytes and a 16-bit time stamp into that mailbox's four-word slot and then raises a one-cycle completion pulse. A per-mailbox enable can attach an interrupt request to that pulse. The slots live in a single-port register array that the CPU also reads and writes. When both want the array in the same cycle, the CPU goes first and the filter write waits.

Top module: `can_accept_filter`

## Requirements
- R1: With masking disabled, a mailbox accepts a frame only if all 29 identifier bits are equal to its stored identifier (slot word 0, bits 28:0).
- R2: For mailboxes 0 to NUM_MB-2, setting word 0 bit 30 applies `glb_mask`, where a mask bit of 1 makes that identifier bit irrelevant. Word 0 bit 31 has no effect on these mailboxes.
- R3: Mailbox NUM_MB-1 applies `lcl_mask` when word 0 bit 31 is set and ignores word 0 bit 30. It accepts frames whatever the value of its direction bit.
- R4: The frame's extension flag must equal word 0 bit 29, and its remote flag must equal word 1 bit 4. For a standard frame (extension flag 0), only identifier bits 28:18 are compared.
- R5: A mailbox from 0 to NUM_MB-2 whose word 1 bit 5 is 0 (transmit) never accepts a frame.
- R6: When several mailboxes accept a frame, only the one with the highest index is written.
- R7: On acceptance, the slot is rewritten as follows. Word 0 bits 28:0 take the frame identifier, with bits 17:0 cleared for a standard frame, and bits 31:29 keep their values. Word 1 bits 31:16 take `ts_now` as sampled in the cycle of `frm_valid`, bit 4 takes the remote flag and bits 3:0 take the DLC, while bits 15:5 keep their values. Word 2 takes data bytes 0 to 3 and word 3 takes bytes 4 to 7, with byte 0 in bits 7:0 of word 2 (`frm_data[7:0]`). Word addresses are slot*4+k.
- R8: `rx_done` is high for exactly one cycle, one cycle after the clock edge that samples `frm_valid` (unless stalled). `rx_mbox` gives the winning index, and `rx_irq` follows that mailbox's word 1 bit 6.
- R9: If `cpu_req` is high in the cycle when the write is pending, the CPU access is served and the write, together with `rx_done`, moves one cycle later. A CPU read in that cycle returns the contents the slot had before the write.
- R10: Reset clears every word and every output. A CPU read returns the addressed word on `cpu_rdata` one cycle after `cpu_req` is sampled, and a CPU write stores `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame header is present |
| frm_id | input | 29 | Frame identifier (standard frames use bits 28:18) |
| frm_ide | input | 1 | Frame uses the extended identifier format |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| ts_now | input | 16 | Free-running time stamp counter |
| glb_mask | input | 29 | Shared mask for the ordinary mailboxes |
| lcl_mask | input | 29 | Private mask for the last mailbox |
| cpu_req | input | 1 | CPU array access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | log2(NUM_MB*4) | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, registered |
| rx_done | output | 1 | One-cycle pulse: a frame was stored |
| rx_mbox | output | log2(NUM_MB) | Index of the mailbox that was written |
| rx_irq | output | 1 | Interrupt request for that store |

## Verification
The assertions assume that frames arrive at least three cycles apart, so that `frm_valid` never falls on a pending write, and that software does not clear a mailbox's direction bit while a frame for that mailbox is in flight. The stimulus enforces both. Each frame is sent only after the previous one has been read back, and every CPU write to the configuration happens between frames. The stall case is made by holding a single CPU read across the pending-write cycle.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int ID_W      = 29;
  localparam int STD_LO    = 18;   // standard identifiers occupy bits 28:18
  localparam int SLOT_WDS  = 4;
  // word 0 bit positions
  localparam int W0_LME    = 31;
  localparam int W0_GME    = 30;
  localparam int W0_EXT    = 29;
  // word 1 bit positions
  localparam int W1_IEN    = 6;
  localparam int W1_RXD    = 5;
  localparam int W1_REM    = 4;

  // Does a frame pass one mailbox's compare? mask bit 1 = ignore that bit.
  function automatic logic id_accept(
    input logic [ID_W-1:0] f_id, input logic f_ext, input logic f_rem,
    input logic [ID_W-1:0] m_id, input logic m_ext, input logic m_rem,
    input logic mask_on, input logic [ID_W-1:0] mask);
    logic [ID_W-1:0] care;
    care = mask_on ? ~mask : '1;
    if (!f_ext) care[STD_LO-1:0] = '0;
    return (f_ext == m_ext) && (f_rem == m_rem) && (((f_id ^ m_id) & care) == '0);
  endfunction

  // Identifier as written back into a slot.
  function automatic logic [ID_W-1:0] stored_id(input logic [ID_W-1:0] f_id, input logic f_ext);
    return f_ext ? f_id : {f_id[ID_W-1:STD_LO], {STD_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/can_af_match.sv
module can_af_match import can_af_pkg::*; #(
  parameter int NUM_MB = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_MB-1:0][31:0]      w0,
  input  logic [NUM_MB-1:0][31:0]      w1,
  input  logic [ID_W-1:0]              f_id,
  input  logic                         f_ext,
  input  logic                         f_rem,
  input  logic [ID_W-1:0]              glb_mask,
  input  logic [ID_W-1:0]              lcl_mask,
  output logic [NUM_MB-1:0]            hit
);
  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic mask_on, rx_ok;
    logic [ID_W-1:0] mask;
    if (g == NUM_MB-1) begin : g_last
      assign mask_on = w0[g][W0_LME];
      assign mask    = lcl_mask;
      assign rx_ok   = 1'b1;
    end else begin : g_norm
      assign mask_on = w0[g][W0_GME];
      assign mask    = glb_mask;
      assign rx_ok   = w1[g][W1_RXD];
    end
    assign hit[g] = rx_ok && id_accept(f_id, f_ext, f_rem, w0[g][ID_W-1:0],
                                       w0[g][W0_EXT], w1[g][W1_REM], mask_on, mask);

    assert_ext_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |-> (w0[g][W0_EXT] == f_ext) && (w1[g][W1_REM] == f_rem));
  end
endmodule

// File: rtl/can_af_prio.sv
module can_af_prio #(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MB-1:0] hit,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // chosen bit is set and nothing above it is
  assert_top_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((hit >> idx) == NUM_MB'(1)));
endmodule

// File: rtl/can_af_store.sv
module can_af_store import can_af_pkg::*; #(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB),
  localparam int DEPTH = NUM_MB * SLOT_WDS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [AW-1:0]             cpu_addr,
  input  logic [31:0]               cpu_wdata,
  output logic [31:0]               cpu_rdata,
  input  logic                      wr_req,
  input  logic [IDX_W-1:0]          wr_slot,
  input  logic [SLOT_WDS-1:0][31:0] wr_words,
  output logic                      wr_grant,
  output logic [NUM_MB-1:0][31:0]   w0,
  output logic [NUM_MB-1:0][31:0]   w1
);
  logic [31:0] mem [DEPTH];

  assign wr_grant = wr_req && !cpu_req;   // CPU owns the port first

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cpu_rdata <= '0;
    end else if (cpu_req) begin
      cpu_rdata <= mem[cpu_addr];
      if (cpu_we) mem[cpu_addr] <= cpu_wdata;
    end else if (wr_req) begin
      for (int k = 0; k < SLOT_WDS; k++) mem[{wr_slot, 2'(k)}] <= wr_words[k];
    end
  end

  for (genvar g = 0; g < NUM_MB; g++) begin : g_view
    assign w0[g] = mem[g*SLOT_WDS];
    assign w1[g] = mem[g*SLOT_WDS+1];
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter import can_af_pkg::*; #(
  parameter int NUM_MB = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frm_valid,
  input  logic [28:0]                        frm_id,
  input  logic                               frm_ide,
  input  logic                               frm_rtr,
  input  logic [3:0]                         frm_dlc,
  input  logic [63:0]                        frm_data,
  input  logic [15:0]                        ts_now,
  input  logic [28:0]                        glb_mask,
  input  logic [28:0]                        lcl_mask,
  input  logic                               cpu_req,
  input  logic                               cpu_we,
  input  logic [$clog2(NUM_MB*4)-1:0]        cpu_addr,
  input  logic [31:0]                        cpu_wdata,
  output logic [31:0]                        cpu_rdata,
  output logic                               rx_done,
  output logic [$clog2(NUM_MB)-1:0]          rx_mbox,
  output logic                               rx_irq
);
  localparam int IDX_W = $clog2(NUM_MB);

  logic [NUM_MB-1:0][31:0] w0, w1;
  logic [NUM_MB-1:0]       hit;
  logic                    any;
  logic [IDX_W-1:0]        win;
  logic                    wr_grant;

  // captured frame awaiting its slot write
  logic             pend;
  logic [IDX_W-1:0] slot_q;
  logic [ID_W-1:0]  id_q;
  logic             ext_q, rem_q;
  logic [3:0]       dlc_q;
  logic [63:0]      data_q;
  logic [15:0]      ts_q;
  logic [SLOT_WDS-1:0][31:0] wr_words;

  can_af_match #(.NUM_MB(NUM_MB)) u_match (
    .clk(clk), .rst_n(rst_n), .w0(w0), .w1(w1),
    .f_id(frm_id), .f_ext(frm_ide), .f_rem(frm_rtr),
    .glb_mask(glb_mask), .lcl_mask(lcl_mask), .hit(hit));

  can_af_prio #(.NUM_MB(NUM_MB)) u_prio (
    .clk(clk), .rst_n(rst_n), .hit(hit), .any(any), .idx(win));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      slot_q <= '0;
      id_q   <= '0;
      ext_q  <= 1'b0;
      rem_q  <= 1'b0;
      dlc_q  <= '0;
      data_q <= '0;
      ts_q   <= '0;
    end else if (frm_valid && any) begin
      pend   <= 1'b1;
      slot_q <= win;
      id_q   <= frm_id;
      ext_q  <= frm_ide;
      rem_q  <= frm_rtr;
      dlc_q  <= frm_dlc;
      data_q <= frm_data;
      ts_q   <= ts_now;
    end else if (wr_grant) begin
      pend <= 1'b0;
    end
  end

  // control bits are re-read at grant time so a CPU update during a stall survives
  assign wr_words[0] = {w0[slot_q][31:ID_W], stored_id(id_q, ext_q)};
  assign wr_words[1] = {ts_q, w1[slot_q][15:5], rem_q, dlc_q};
  assign wr_words[2] = data_q[31:0];
  assign wr_words[3] = data_q[63:32];

  can_af_store #(.NUM_MB(NUM_MB)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .wr_req(pend), .wr_slot(slot_q), .wr_words(wr_words),
    .wr_grant(wr_grant), .w0(w0), .w1(w1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_done <= 1'b0;
      rx_mbox <= '0;
      rx_irq  <= 1'b0;
    end else begin
      rx_done <= wr_grant;
      rx_irq  <= wr_grant && w1[slot_q][W1_IEN];
      if (wr_grant) rx_mbox <= slot_q;
    end
  end

  assert_cpu_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cpu_req) |=> (pend && !rx_done));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  assert_frame_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> !pend);
  assert_rx_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ((rx_mbox == IDX_W'(NUM_MB-1)) || w1[rx_mbox][W1_RXD]));
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  localparam int NMB = 32;
  localparam int AW  = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frm_valid = 0, frm_ide = 0, frm_rtr = 0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic [15:0] ts_now = '0;
  logic [28:0] glb_mask = 29'h000000FF;
  logic [28:0] lcl_mask = 29'h1F000000;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic rx_done, rx_irq;
  logic [4:0] rx_mbox;

  int nvec = 0, nbad = 0, nfr = 0;
  bit finished = 0;
  logic [31:0] m [NMB*4];   // expected array contents

  always #10 clk = ~clk;     // 50 MHz

  can_accept_filter #(.NUM_MB(NMB)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .ts_now(ts_now), .glb_mask(glb_mask), .lcl_mask(lcl_mask),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rx_done(rx_done), .rx_mbox(rx_mbox), .rx_irq(rx_irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %h expected %h (frame %0d)", tag, act, exp, nfr);
    end
  endtask

  task automatic cpu_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = AW'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    m[a] = d;
  endtask

  task automatic cpu_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = AW'(a);
    @(negedge clk);
    cpu_req = 0;
    d = cpu_rdata;
  endtask

  // Expected winner: scan from the top, the first mailbox that accepts wins.
  function automatic int exp_win(input logic [28:0] id, input logic ide, input logic rtr);
    for (int i = NMB-1; i >= 0; i--) begin
      logic [31:0] a, b;
      bit ok, use_m;
      logic [28:0] mk;
      a = m[i*4]; b = m[i*4+1];
      ok = (a[29] == ide) && (b[4] == rtr);
      if (i < NMB-1 && !b[5]) ok = 0;
      use_m = (i == NMB-1) ? a[31] : a[30];
      mk    = (i == NMB-1) ? lcl_mask : glb_mask;
      for (int k = 0; k < 29; k++) begin
        if (!ide && k < 18) continue;
        if (use_m && mk[k]) continue;
        if (id[k] != a[k]) ok = 0;
      end
      if (ok) return i;
    end
    return -1;
  endfunction

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                      input string tag, input bit hold);
    int w;
    logic [3:0] dlc;
    logic [63:0] dat;
    logic [15:0] ts;
    logic [31:0] rv;
    nfr++;
    dlc = 4'(nfr % 9);
    dat = {32'(nfr) * 32'h9E3779B9, (32'(nfr) * 32'h85EBCA6B) ^ 32'hFFFF0000};
    ts  = 16'(nfr * 4951 + 3);
    w = exp_win(id, ide, rtr);
    @(negedge clk);
    frm_valid = 1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
    frm_dlc = dlc; frm_data = dat; ts_now = ts;
    @(negedge clk);
    frm_valid = 0; ts_now = ~ts;
    if (hold) begin
      cpu_req = 1; cpu_we = 0; cpu_addr = AW'((w < 0 ? 0 : w) * 4 + 1);
      @(negedge clk);
      cpu_req = 0;
      chk(cpu_rdata == m[(w < 0 ? 0 : w) * 4 + 1], "R9 old data", cpu_rdata, m[(w < 0 ? 0 : w) * 4 + 1]);
      chk(rx_done == 1'b0, "R9 stall", 32'(rx_done), 0);
      @(negedge clk);
    end else begin
      @(negedge clk);
    end
    chk(rx_done == (w >= 0), tag, 32'(rx_done), 32'(w >= 0));
    if (w >= 0) begin
      chk(rx_mbox == 5'(w), "R8 index", 32'(rx_mbox), 32'(w));
      chk(rx_irq == m[w*4+1][6], "R8 irq", 32'(rx_irq), 32'(m[w*4+1][6]));
      m[w*4]   = {m[w*4][31:29], ide ? id : {id[28:18], 18'b0}};
      m[w*4+1] = {ts, m[w*4+1][15:5], rtr, dlc};
      m[w*4+2] = dat[31:0];
      m[w*4+3] = dat[63:32];
      @(negedge clk);
      chk(rx_done == 1'b0, "R8 pulse", 32'(rx_done), 0);
      for (int k = 0; k < 4; k++) begin
        cpu_rd(w*4+k, rv);
        chk(rv == m[w*4+k], "R7 slot word", rv, m[w*4+k]);
      end
    end
  endtask

  initial begin
    logic [31:0] rv;
    for (int i = 0; i < NMB*4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rx_done == 0 && rx_irq == 0, "R10 reset outputs", 32'(rx_done), 0);
    for (int a = 0; a < NMB*4; a += 29) begin
      cpu_rd(a, rv);
      chk(rv == 32'h0, "R10 reset word", rv, 0);
    end
    // configure mailboxes
    for (int i = 0; i < NMB; i++) begin
      bit std, gme, lme, rxd, ien, rem;
      logic [28:0] id;
      std = (i % 4 == 3) && (i != NMB-1);
      gme = (i == 9) || (i == NMB-1);
      lme = (i == 9) || (i == NMB-1);
      rxd = (i != 7) && (i != NMB-1);
      ien = (i % 2 == 1);
      rem = (i == 13);
      id  = std ? {11'(i), 18'b0} : {5'(i), 24'(i * 4099 + 17)};
      cpu_wr(i*4,   {lme, gme, !std, id});
      cpu_wr(i*4+1, {25'b0, ien, rxd, rem, 4'b0});
    end
    cpu_rd(9*4, rv);
    chk(rv == m[9*4], "R10 cpu write/read", rv, m[9*4]);
    // sweep: per mailbox, exact and perturbed frames
    for (int i = 0; i < NMB; i++) begin
      logic [28:0] id;
      logic ide, rtr;
      string t1;
      id = m[i*4][28:0]; ide = m[i*4][29]; rtr = m[i*4+1][4];
      t1 = (i == 7) ? "R5 tx mailbox" : (i == NMB-1) ? "R3 last" : "R1 exact";
      send(id, ide, rtr, t1, 0);
      id = m[i*4][28:0];
      send(id ^ 29'h1, ide, rtr, (i == 9) ? "R2 global mask" : "R1 bit0", 0);
      id = m[i*4][28:0];
      send(id ^ 29'h100000, ide, rtr, "R4 bit20", 0);
      id = m[i*4][28:0];
      send(id, !ide, rtr, "R4 format flag", 0);
      id = m[i*4][28:0];
      send(id ^ 29'h10000000, ide, rtr, (i == NMB-1) ? "R3 local mask" : "R1 bit28", 0);
      id = m[i*4][28:0];
      send(id, ide, !rtr, "R4 remote flag", 0);
    end
    // priority: mailbox 2 copies mailbox 20's filter
    cpu_wr(2*4, m[20*4]);
    send(m[20*4][28:0], m[20*4][29], 1'b0, "R6 highest wins", 0);
    chk(exp_win(m[20*4][28:0], 1'b1, 1'b0) == 20, "R6 model", 32'(exp_win(m[20*4][28:0], 1'b1, 1'b0)), 20);
    cpu_wr(20*4+1, m[20*4+1] & ~32'h20);
    send(m[2*4][28:0], m[2*4][29], 1'b0, "R6 lower after tx", 0);
    // CPU conflict
    send(m[5*4][28:0], m[5*4][29], m[5*4+1][4], "R9 delayed done", 1);
    send(m[NMB*4-4][28:0], m[NMB*4-4][29], 1'b0, "R9 delayed last", 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule